// File: doc/BRIEF.md
# Packet Memory Access Arbiter with Byte-Lane Control

This block gives two requesters turns at a single external packet SRAM. The SRAM is a 32-bit word made from four 8-bit-wide devices. One requester is the host path, which performs pipelined accesses to the data register. The other is the DMA path, which moves MAC frame data. Each requester holds a request level together with a byte address, byte enables, write data and a write flag. It keeps them steady until the block pulses that requester's done output.

Every access runs as one fixed four-clock sequence: arbitration, address setup, strobe or sample, and done. At a 50 MHz clock this fits in 80 ns. On writes the four active-low lane strobes follow the byte enables. On reads the whole 32-bit word is always fetched. The requested byte, halfword or word is then shifted down to the low lanes, and the unused upper lanes are cleared. When both requesters wait at once, the grant alternates between them.

Top module: `pktram_arbiter`

## Requirements
- R1: While `rst` is high and on the first clock after it falls, `sram_oe_n` is 1, `sram_we_n` is 4'b1111, `sram_dq_oe` is 0 and both done outputs are 0. Requests held during reset are ignored.
- R2: A request seen in the idle state is granted on that clock edge. The address is driven in the next cycle and the strobe/sample cycle follows. The owner's done is high in the third cycle after the grant edge, for exactly one cycle, and never for both requesters at once. The block is idle again in the fourth cycle.
- R3: `sram_addr` equals the byte address bits [16:2] of the granted request. It is held unchanged from the address cycle through the done cycle.
- R4: On a write, `sram_we_n[i]` is 0 only in the strobe cycle and only where byte enable bit i is 1. All strobes are 1 in the done cycle, one clock before the address may change.
- R5: `sram_oe_n` is 0 only in the address and strobe cycles of a read. It is never 0 while any write strobe is 0.
- R6: Reads always fetch all 32 bits. The captured word is shifted right by 8×address[1:0]. If one byte enable is set, the result keeps lane 0. If two are set, it keeps lanes 1..0. Otherwise it keeps all four lanes. Lanes that are not kept return zero. On reads, only the count of set enables matters, not their positions.
- R7: When both requesters are pending in the idle state, the one not served last is granted. After reset, a tie goes to the host.
- R8: A lone pending requester is granted on the next idle edge, even if it was also served last.
- R9: On a write, `sram_dq_oe` is 1 and `sram_dq_out` equals the requester's write data, from the address cycle through the done cycle.
- R10: The steered read result appears on the owner's read-data output during its done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_req | input | 1 | Host request, held until hst_done |
| hst_we | input | 1 | Host write flag (1 = write) |
| hst_addr | input | 17 | Host byte address |
| hst_be | input | 4 | Host byte enables, bit i = lane i |
| hst_wdata | input | 32 | Host write data, lane-aligned |
| hst_done | output | 1 | Host access complete pulse |
| hst_rdata | output | 32 | Host steered read data |
| dma_req | input | 1 | DMA request, held until dma_done |
| dma_we | input | 1 | DMA write flag |
| dma_addr | input | 17 | DMA byte address |
| dma_be | input | 4 | DMA byte enables |
| dma_wdata | input | 32 | DMA write data, lane-aligned |
| dma_done | output | 1 | DMA access complete pulse |
| dma_rdata | output | 32 | DMA steered read data |
| sram_addr | output | 15 | SRAM word address |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 4 | Per-lane write strobes, active low |
| sram_dq_out | output | 32 | Data driven toward the SRAM |
| sram_dq_oe | output | 1 | Drive enable for sram_dq_out |
| sram_dq_in | input | 32 | Data read from the SRAM |

## Verification
The address and output enable are due in the first cycle after the grant edge, and write strobes in the second. The done pulse and the steered read data are due in the third, and the idle state returns in the fourth. The bench starts each request at a falling edge and counts rising edges from the grant. It samples at the falling edge inside the exact cycle where each result must appear. It also checks the neighbouring cycles for strobes, enables and done being absent. The alternation test holds both requests and expects each done exactly four cycles after the previous one.

// File: rtl/pktram_pkg.sv
package pktram_pkg;

    localparam int unsigned PK_LANES   = 4;
    localparam int unsigned PK_BYTE_W  = 8;
    localparam int unsigned PK_WADDR_W = 15;

    localparam int unsigned PK_SRC_HOST = 0;
    localparam int unsigned PK_SRC_DMA  = 1;
    localparam int unsigned PK_NUM_SRC  = 2;

    typedef enum logic [1:0] {
        SEQ_ARB  = 2'd0,
        SEQ_ADDR = 2'd1,
        SEQ_STRB = 2'd2,
        SEQ_DONE = 2'd3
    } seq_e;

    typedef struct packed {
        logic owner;   // 0 = host, 1 = dma
        logic is_wr;
    } cyc_tag_t;

    function automatic seq_e seq_next(input seq_e s, input logic start);
        case (s)
            SEQ_ARB:  return start ? SEQ_ADDR : SEQ_ARB;
            SEQ_ADDR: return SEQ_STRB;
            SEQ_STRB: return SEQ_DONE;
            default:  return SEQ_ARB;
        endcase
    endfunction

    function automatic logic seq_mem_active(input seq_e s);
        return (s == SEQ_ADDR) || (s == SEQ_STRB);
    endfunction

endpackage

// File: rtl/pktram_rr_arb.sv
module pktram_rr_arb #(
    parameter  int unsigned N  = pktram_pkg::PK_NUM_SRC,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         advance,
    output logic [N-1:0] gnt
);
    logic [IW-1:0] last_q;
    logic [IW-1:0] win_idx;
    logic [IW-1:0] idx;

    always_comb begin
        gnt     = '0;
        win_idx = last_q;
        idx     = '0;
        for (int k = 0; k < int'(N); k++) begin
            idx = IW'((32'(last_q) + 32'd1 + 32'(k)) % N);
            if (req[idx] && (gnt == '0)) begin
                gnt[idx] = 1'b1;
                win_idx  = idx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= IW'(N - 1);
        end else if (advance) begin
            last_q <= win_idx;
        end
    end
endmodule

// File: rtl/pktram_lane_steer.sv
module pktram_lane_steer #(
    parameter  int unsigned LANES  = pktram_pkg::PK_LANES,
    parameter  int unsigned BYTE_W = pktram_pkg::PK_BYTE_W,
    localparam int unsigned DATA_W = LANES * BYTE_W,
    localparam int unsigned OFF_W  = $clog2(LANES)
) (
    input  logic [DATA_W-1:0] word,
    input  logic [OFF_W-1:0]  off,
    input  logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] data
);
    logic [DATA_W-1:0] shifted;
    int unsigned       keep;

    always_comb begin
        shifted = word >> (32'(off) * BYTE_W);
    end

    always_comb begin
        case ($countones(be))
            1:       keep = 1;
            2:       keep = 2;
            default: keep = LANES;
        endcase
    end

    for (genvar i = 0; i < int'(LANES); i++) begin : g_lane
        assign data[i*BYTE_W +: BYTE_W] =
            (i < keep) ? shifted[i*BYTE_W +: BYTE_W] : '0;
    end
endmodule

// File: rtl/pktram_strobe_gen.sv
module pktram_strobe_gen #(
    parameter int unsigned LANES = pktram_pkg::PK_LANES
) (
    input  logic             active,
    input  logic [LANES-1:0] be,
    output logic [LANES-1:0] we_n
);
    for (genvar i = 0; i < int'(LANES); i++) begin : g_strb
        assign we_n[i] = ~(active & be[i]);
    end
endmodule

// File: rtl/pktram_arbiter.sv
module pktram_arbiter #(
    parameter  int unsigned LANES   = pktram_pkg::PK_LANES,
    parameter  int unsigned BYTE_W  = pktram_pkg::PK_BYTE_W,
    parameter  int unsigned WADDR_W = pktram_pkg::PK_WADDR_W,
    localparam int unsigned DATA_W  = LANES * BYTE_W,
    localparam int unsigned OFF_W   = $clog2(LANES),
    localparam int unsigned ADDR_W  = WADDR_W + OFF_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hst_req,
    input  logic               hst_we,
    input  logic [ADDR_W-1:0]  hst_addr,
    input  logic [LANES-1:0]   hst_be,
    input  logic [DATA_W-1:0]  hst_wdata,
    output logic               hst_done,
    output logic [DATA_W-1:0]  hst_rdata,
    input  logic               dma_req,
    input  logic               dma_we,
    input  logic [ADDR_W-1:0]  dma_addr,
    input  logic [LANES-1:0]   dma_be,
    input  logic [DATA_W-1:0]  dma_wdata,
    output logic               dma_done,
    output logic [DATA_W-1:0]  dma_rdata,
    output logic [WADDR_W-1:0] sram_addr,
    output logic               sram_oe_n,
    output logic [LANES-1:0]   sram_we_n,
    output logic [DATA_W-1:0]  sram_dq_out,
    output logic               sram_dq_oe,
    input  logic [DATA_W-1:0]  sram_dq_in
);
    import pktram_pkg::*;

    localparam int unsigned NSRC = PK_NUM_SRC;

    seq_e              state_q;
    cyc_tag_t          tag_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LANES-1:0]  be_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;

    logic [NSRC-1:0]   req_vec;
    logic [NSRC-1:0]   gnt;
    logic              start;
    logic              pick_dma;
    logic [DATA_W-1:0] steered;
    logic              strobe_on;

    assign req_vec[PK_SRC_HOST] = hst_req;
    assign req_vec[PK_SRC_DMA]  = dma_req;
    assign start    = (state_q == SEQ_ARB) && (gnt != '0);
    assign pick_dma = gnt[PK_SRC_DMA];

    pktram_rr_arb #(.N(NSRC)) u_rr (
        .clk     (clk),
        .rst     (rst),
        .req     (req_vec),
        .advance (start),
        .gnt     (gnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_ARB;
            tag_q   <= '0;
            addr_q  <= '0;
            be_q    <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= seq_next(state_q, start);
            if (start) begin
                tag_q.owner <= pick_dma;
                tag_q.is_wr <= pick_dma ? dma_we    : hst_we;
                addr_q      <= pick_dma ? dma_addr  : hst_addr;
                be_q        <= pick_dma ? dma_be    : hst_be;
                wdata_q     <= pick_dma ? dma_wdata : hst_wdata;
            end
        end
    end

    pktram_lane_steer #(.LANES(LANES), .BYTE_W(BYTE_W)) u_steer (
        .word (sram_dq_in),
        .off  (addr_q[OFF_W-1:0]),
        .be   (be_q),
        .data (steered)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if ((state_q == SEQ_STRB) && !tag_q.is_wr) begin
            rdata_q <= steered;
        end
    end

    assign strobe_on = (state_q == SEQ_STRB) && tag_q.is_wr;

    pktram_strobe_gen #(.LANES(LANES)) u_strb (
        .active (strobe_on),
        .be     (be_q),
        .we_n   (sram_we_n)
    );

    assign sram_addr   = addr_q[ADDR_W-1:OFF_W];
    assign sram_oe_n   = ~(seq_mem_active(state_q) && !tag_q.is_wr);
    assign sram_dq_oe  = (state_q != SEQ_ARB) && tag_q.is_wr;
    assign sram_dq_out = wdata_q;

    assign hst_done  = (state_q == SEQ_DONE) && !tag_q.owner;
    assign dma_done  = (state_q == SEQ_DONE) &&  tag_q.owner;
    assign hst_rdata = rdata_q;
    assign dma_rdata = rdata_q;
endmodule

// File: rtl/pktram_arbiter_chk.sv
module pktram_arbiter_chk #(
    parameter int unsigned LANES   = 4,
    parameter int unsigned WADDR_W = 15
) (
    input logic               clk,
    input logic               rst,
    input logic               hst_done,
    input logic               dma_done,
    input logic [WADDR_W-1:0] sram_addr,
    input logic               sram_oe_n,
    input logic [LANES-1:0]   sram_we_n,
    input logic               sram_dq_oe
);
    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        rst |=> (sram_oe_n && (&sram_we_n) && !sram_dq_oe && !hst_done && !dma_done)); // R1

    AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hst_done, dma_done})); // R2

    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (hst_done || dma_done) |=> !(hst_done || dma_done)); // R2

    AST_STROBE_THEN_DONE: assert property (@(posedge clk) disable iff (rst)
        !(&sram_we_n) |=> (hst_done || dma_done)); // R2

    AST_ADDR_HELD_ON_READ: assert property (@(posedge clk) disable iff (rst)
        (!sram_oe_n && $past(!sram_oe_n)) |-> $stable(sram_addr)); // R3

    AST_STROBE_RELEASE: assert property (@(posedge clk) disable iff (rst)
        !(&sram_we_n) |=> ((&sram_we_n) && $stable(sram_addr))); // R4

    AST_OE_WE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(!sram_oe_n && !(&sram_we_n))); // R5

    AST_DRIVE_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
        !(&sram_we_n) |-> sram_dq_oe); // R9
endmodule

bind pktram_arbiter pktram_arbiter_chk #(.LANES(LANES), .WADDR_W(WADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .hst_done   (hst_done),
    .dma_done   (dma_done),
    .sram_addr  (sram_addr),
    .sram_oe_n  (sram_oe_n),
    .sram_we_n  (sram_we_n),
    .sram_dq_oe (sram_dq_oe)
);

// File: tb/tb_pktram_arbiter.sv
`timescale 1ns/1ps
module tb_pktram_arbiter;

    logic        clk = 1'b0;
    logic        rst;
    logic        hst_req, hst_we, dma_req, dma_we;
    logic [16:0] hst_addr, dma_addr;
    logic [3:0]  hst_be, dma_be;
    logic [31:0] hst_wdata, dma_wdata;
    logic        hst_done, dma_done;
    logic [31:0] hst_rdata, dma_rdata;
    logic [14:0] sram_addr;
    logic        sram_oe_n, sram_dq_oe;
    logic [3:0]  sram_we_n;
    logic [31:0] sram_dq_out, sram_dq_in;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pktram_arbiter dut (
        .clk(clk), .rst(rst),
        .hst_req(hst_req), .hst_we(hst_we), .hst_addr(hst_addr), .hst_be(hst_be),
        .hst_wdata(hst_wdata), .hst_done(hst_done), .hst_rdata(hst_rdata),
        .dma_req(dma_req), .dma_we(dma_we), .dma_addr(dma_addr), .dma_be(dma_be),
        .dma_wdata(dma_wdata), .dma_done(dma_done), .dma_rdata(dma_rdata),
        .sram_addr(sram_addr), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
        .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    // Behavioural SRAM: 256 words, asynchronous read, lane writes on strobe.
    logic [31:0] mem [256];
    initial for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    assign sram_dq_in = mem[sram_addr[7:0]];
    always @(posedge clk) begin
        for (int l = 0; l < 4; l++)
            if (!sram_we_n[l]) mem[sram_addr[7:0]][l*8 +: 8] <= sram_dq_out[l*8 +: 8];
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic        dma;
        logic        we;
        logic [16:0] addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b1, 17'h00010, 4'hF, 32'hA1B2C3D4, 32'h0},
        '{1'b1, 1'b1, 17'h00014, 4'hF, 32'h11223344, 32'h0},
        '{1'b0, 1'b0, 17'h00010, 4'hF, 32'h0,        32'hA1B2C3D4},
        '{1'b1, 1'b0, 17'h00011, 4'h2, 32'h0,        32'h000000C3},
        '{1'b0, 1'b0, 17'h00012, 4'hC, 32'h0,        32'h0000A1B2},
        '{1'b1, 1'b0, 17'h00013, 4'h8, 32'h0,        32'h000000A1},
        '{1'b0, 1'b1, 17'h00014, 4'h4, 32'h00EE0000, 32'h0},
        '{1'b1, 1'b0, 17'h00014, 4'hF, 32'h0,        32'h11EE3344},
        '{1'b0, 1'b0, 17'h00015, 4'h6, 32'h0,        32'h0000EE33},
        '{1'b0, 1'b1, 17'h00018, 4'h3, 32'h0000BEEF, 32'h0},
        '{1'b1, 1'b0, 17'h00018, 4'h1, 32'h0,        32'h000000EF},
        '{1'b1, 1'b0, 17'h0001A, 4'hF, 32'h0,        32'h00000000}
    };

    task automatic idle_inputs();
        hst_req = 0; hst_we = 0; hst_addr = '0; hst_be = '0; hst_wdata = '0;
        dma_req = 0; dma_we = 0; dma_addr = '0; dma_be = '0; dma_wdata = '0;
    endtask

    // Called at a falling edge with the block idle; returns at a falling edge, idle.
    task automatic do_access(input vec_t v);
        logic own_done, oth_done;
        logic [31:0] rd;
        if (v.dma) begin
            dma_req = 1; dma_we = v.we; dma_addr = v.addr; dma_be = v.be; dma_wdata = v.wdata;
        end else begin
            hst_req = 1; hst_we = v.we; hst_addr = v.addr; hst_be = v.be; hst_wdata = v.wdata;
        end
        @(posedge clk); @(negedge clk);          // address cycle
        own_done = v.dma ? dma_done : hst_done;
        chk("R2 done early", {31'b0, own_done}, 32'd0);
        chk("R3 address", {17'b0, sram_addr}, {17'b0, v.addr[16:2]});
        chk("R5 oe in address cycle", {31'b0, sram_oe_n}, {31'b0, v.we});
        chk("R4 no strobe in address cycle", {28'b0, sram_we_n}, 32'hF);
        if (v.we) begin
            chk("R9 drive enable", {31'b0, sram_dq_oe}, 32'd1);
            chk("R9 write data", sram_dq_out, v.wdata);
        end
        @(posedge clk); @(negedge clk);          // strobe cycle
        chk("R4 strobes", {28'b0, sram_we_n}, v.we ? {28'b0, ~v.be} : 32'hF);
        chk("R5 oe in strobe cycle", {31'b0, sram_oe_n}, {31'b0, v.we});
        @(posedge clk); @(negedge clk);          // done cycle
        own_done = v.dma ? dma_done : hst_done;
        oth_done = v.dma ? hst_done : dma_done;
        chk("R2 R8 done due", {31'b0, own_done}, 32'd1);
        chk("R2 other done", {31'b0, oth_done}, 32'd0);
        chk("R4 strobes released", {28'b0, sram_we_n}, 32'hF);
        chk("R3 address held", {17'b0, sram_addr}, {17'b0, v.addr[16:2]});
        chk("R5 oe off in done", {31'b0, sram_oe_n}, 32'd1);
        if (!v.we) begin
            rd = v.dma ? dma_rdata : hst_rdata;
            chk("R6 R10 read data", rd, v.exp);
        end
        if (v.dma) dma_req = 0; else hst_req = 0;
        @(posedge clk); @(negedge clk);          // idle again
        chk("R2 done cleared", {30'b0, hst_done, dma_done}, 32'd0);
    endtask

    task automatic apply_reset();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1;
        hst_req = 1; hst_addr = 17'h00010; hst_be = 4'hF;   // ignored during reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 oe idle", {31'b0, sram_oe_n}, 32'd1);
        chk("R1 strobes idle", {28'b0, sram_we_n}, 32'hF);
        chk("R1 no drive", {31'b0, sram_dq_oe}, 32'd0);
        chk("R1 no done", {30'b0, hst_done, dma_done}, 32'd0);
        hst_req = 0;
        rst = 0;
        @(negedge clk);
        chk("R1 first clock after reset", {30'b0, hst_done, dma_done, sram_oe_n}, 32'd1);

        for (int n = 0; n < NV; n++) do_access(VEC[n]);

        // R7: tie after reset goes to host, then alternates.
        apply_reset();
        hst_req = 1; hst_we = 0; hst_addr = 17'h00010; hst_be = 4'hF;
        dma_req = 1; dma_we = 0; dma_addr = 17'h00014; dma_be = 4'hF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 host first", {30'b0, hst_done, dma_done}, 32'd2);
        chk("R7 host data", hst_rdata, 32'hA1B2C3D4);
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R7 dma second", {30'b0, hst_done, dma_done}, 32'd1);
        chk("R7 dma data", dma_rdata, 32'h11EE3344);
        dma_req = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R8 host alone again", {30'b0, hst_done, dma_done}, 32'd2);
        hst_req = 0;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule